// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash device. It takes one high-level request at a time on a valid/ready command port. A request is a read, a byte program, a sector erase, a whole-chip erase, an identifier read or a return-to-read. The block turns each request into the bus activity the flash expects. For a modifying request it sends a fixed burst of unlock and command writes, then repeatedly reads the device until the internal operation has finished.

Completion is detected in one of two ways, chosen per request by a configuration input. In the first, bit 7 of the status read must match the expected final value. In the second, bit 6 must stop alternating between successive reads. If the operation does not finish within a budget of clock cycles, the block sends a return-to-read write and then reports completion with an error flag set. Write-pulse width, write recovery, read access and the timeout budget are all counts of clock cycles set by parameters.

Top module: `flashctl_top`

## Requirements
- R1: After reset, chip enable, output enable and write enable are high (inactive), the data bus is not driven, `cmdReady` is 1 and `rspDone` is 0.
- R2: A program request (cmdOp 1) issues exactly four writes, in this order: address 5555h with data AAh, 2AAAh with 55h, 5555h with A0h, then the request address with the request data.
- R3: A sector erase request (cmdOp 2) issues exactly six writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the request address with 30h.
- R4: A chip erase request (cmdOp 3) issues the same first five writes as R3 and then 5555h/10h as its sixth write.
- R5: Every write first presents its address and data for one cycle with chip enable low and write enable high. Write enable is then low for exactly WP_CYC cycles with address and data unchanged. The bus stays driven with the same data on the cycle that write enable returns high. Write enable then stays high for at least WPH_CYC cycles before the next write. Write enable and output enable are never low together.
- R6: A read request (cmdOp 0) makes no write. It holds chip enable and output enable low for exactly ACC_CYC cycles at the request address, with write enable high and the bus undriven. It returns the byte present on the last of those cycles on `rspData`, with `rspDone` high ACC_CYC+2 cycles after acceptance.
- R7: With `pollToggle` 0, after the last command write the block reads the request address until bit 7 of the read equals bit 7 of the programmed data (1 for either erase). It then raises `rspDone` with `rspTimeout` 0, and `rspData` holds the final read. A device that stays busy for N reads therefore costs N+1 status reads.
- R8: With `pollToggle` 1, polling ends on the first read whose bit 6 equals bit 6 of the read just before it. This takes at least two reads, with output enable high for at least one cycle between reads. A device that alternates bit 6 for N reads and then holds it costs N+2 reads.
- R9: If polling has run TIMEOUT_CYC cycles without success, the block issues one extra write of F0h to address 0. It then raises `rspDone` with `rspTimeout` 1.
- R10: An identifier request (cmdOp 4) writes 5555h/AAh, 2AAAh/55h, 5555h/90h. It then reads the address whose bit 0 is bit 0 of the request address (0 selects the maker code, 1 the device code) and whose other bits are 0. It then writes F0h to address 0 and returns the byte read.
- R11: A return-to-read request (cmdOp 5, and the unused codes 6 and 7) issues the single write F0h to address 0, with `rspDone` high 1+WP_CYC+WPH_CYC cycles after acceptance.
- R12: `cmdReady` is 0 from the cycle after a request is accepted until the request completes. A request held valid during that time is ignored and adds no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Block idle and accepting a request |
| cmdOp | input | 3 | Request kind: 0 read, 1 program, 2 sector erase, 3 chip erase, 4 identifier, 5 return-to-read |
| cmdAddr | input | ADDR_W | Request address |
| cmdData | input | 8 | Byte to program |
| pollToggle | input | 1 | Completion method: 0 bit-7 compare, 1 bit-6 toggle |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Last byte read from the device |
| rspTimeout | output | 1 | With rspDone: polling budget expired |
| flAddr | output | ADDR_W | Flash address bus |
| flDqOut | output | 8 | Flash data bus, host-driven value |
| flDqOe | output | 1 | Host drives the data bus |
| flDqIn | input | 8 | Flash data bus, device-driven value |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Output enable, active low |
| flWeN | output | 1 | Write enable, active low |

## Verification
The bench places its own flash model on the pins. Every result is tied to a fixed cycle count. A read completes ACC_CYC+2 cycles after acceptance, a lone return-to-read write 1+WP_CYC+WPH_CYC cycles after, and a status read costs ACC_CYC+2 cycles per iteration. The bench drives inputs and samples outputs only on falling clock edges and counts whole cycles from the first falling edge after acceptance, so an exact latency compare lands on the cycle where `rspDone` is due. The model measures each strobe phase in whole cycles and logs every write on the rising edge of write enable. The pass/fail checks therefore look at the ordered write log, the number of status reads and the pulse lengths, none of which depend on where within a cycle the edges fall.

// File: rtl/flashctl_pkg.sv
`timescale 1ns/1ps
package flashctl_pkg;

  typedef enum logic [2:0] {
    OP_READ = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_CHIP = 3'd3,
    OP_ID   = 3'd4,
    OP_RST  = 3'd5
  } opKind_e;

  typedef enum logic [2:0] {
    AS_UNLK1,
    AS_UNLK2,
    AS_CMD,
    AS_IDOFS,
    AS_ZERO
  } addrSel_e;

  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERASE = 8'h80;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_EXIT  = 8'hF0;

  typedef struct packed {
    addrSel_e   addrSel;
    logic       useCmdData;
    logic [7:0] code;
  } wrStep_t;

  typedef struct packed {
    logic       ceN;
    logic       oeN;
    logic       weN;
    logic       drive;
    wrStep_t    step;
    logic       capture;
    logic       latchCmd;
    logic       pollClr;
    logic       pollStep;
    logic       expOne;
  } strobe_t;

endpackage

// File: rtl/flashctl_dp.sv
`timescale 1ns/1ps
module flashctl_dp
  import flashctl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int WP_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              pollToggle,
  input  logic [7:0]        flDqIn,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic [7:0]        rdData,
  output logic              pollOk
);

  localparam int WLC_W = $clog2(WP_CYC + 2);

  logic [ADDR_W-1:0] cmdAddrQ;
  logic [7:0]        cmdDataQ;
  logic              toggleQ;
  logic              capQ;
  logic              havePrev;
  logic              prevBit6;
  logic [ADDR_W-1:0] addrNext;
  logic [7:0]        dataNext;
  logic [WLC_W-1:0]  weLowCnt;

  always_comb begin
    case (stb.step.addrSel)
      AS_UNLK1: addrNext = ADDR_W'(16'h5555);
      AS_UNLK2: addrNext = ADDR_W'(16'h2AAA);
      AS_CMD:   addrNext = cmdAddrQ;
      AS_IDOFS: addrNext = {{(ADDR_W-1){1'b0}}, cmdAddrQ[0]};
      default:  addrNext = '0;
    endcase
    dataNext = stb.step.useCmdData ? cmdDataQ : stb.step.code;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddrQ <= '0;
      cmdDataQ <= '0;
      toggleQ  <= 1'b0;
      flAddr   <= '0;
      flDqOut  <= '0;
      flDqOe   <= 1'b0;
      flCeN    <= 1'b1;
      flOeN    <= 1'b1;
      flWeN    <= 1'b1;
      capQ     <= 1'b0;
      rdData   <= '0;
      havePrev <= 1'b0;
      prevBit6 <= 1'b0;
    end else begin
      if (stb.latchCmd) begin
        cmdAddrQ <= cmdAddr;
        cmdDataQ <= cmdData;
        toggleQ  <= pollToggle;
      end
      flAddr  <= addrNext;
      flDqOut <= dataNext;
      flDqOe  <= stb.drive;
      flCeN   <= stb.ceN;
      flOeN   <= stb.oeN;
      flWeN   <= stb.weN;
      capQ    <= stb.capture;
      if (capQ) rdData <= flDqIn;
      if (stb.pollClr) begin
        havePrev <= 1'b0;
      end else if (stb.pollStep) begin
        havePrev <= 1'b1;
        prevBit6 <= rdData[6];
      end
    end
  end

  always_comb begin
    if (toggleQ) pollOk = havePrev && (rdData[6] == prevBit6);
    else         pollOk = rdData[7] == (stb.expOne ? 1'b1 : cmdDataQ[7]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)       weLowCnt <= '0;
    else if (!flWeN) weLowCnt <= weLowCnt + 1'b1;
    else             weLowCnt <= '0;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!flWeN && !flOeN));

  // R5
  we_ce_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> (!flCeN && flDqOe));

  // R5
  wr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDqOut)));

  // R5
  wp_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> (weLowCnt == WLC_W'(WP_CYC)));

  // R6
  read_undriven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flOeN |-> !flDqOe);

endmodule

// File: rtl/flashctl_ctrl.sv
`timescale 1ns/1ps
module flashctl_ctrl
  import flashctl_pkg::*;
#(
  parameter int WP_CYC      = 3,
  parameter int WPH_CYC     = 2,
  parameter int ACC_CYC     = 5,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       pollOk,
  output logic       cmdReady,
  output strobe_t    stb,
  output logic       rspDone,
  output logic       rspTimeout
);

  localparam int MAXPH = (WP_CYC > WPH_CYC) ? ((WP_CYC > ACC_CYC) ? WP_CYC : ACC_CYC)
                                            : ((WPH_CYC > ACC_CYC) ? WPH_CYC : ACC_CYC);
  localparam int CNT_W = $clog2(MAXPH + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WLOW, ST_WHIGH, ST_RACC, ST_RGAP, ST_REVAL, ST_DONE
  } state_e;

  state_e     state;
  opKind_e    opQ;
  opKind_e    opIn;
  logic [2:0] wrIdx;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] timer;
  logic       exitWr;
  logic       timedOut;
  logic       polling;
  logic       lastWr;

  function automatic logic [2:0] lastIdx(opKind_e op);
    case (op)
      OP_PROG:         return 3'd3;
      OP_SECT, OP_CHIP: return 3'd5;
      OP_ID:           return 3'd2;
      default:         return 3'd0;
    endcase
  endfunction

  function automatic wrStep_t stepOf(opKind_e op, logic [2:0] idx);
    case (idx)
      3'd0: return '{AS_UNLK1, 1'b0, CODE_KEY1};
      3'd1: return '{AS_UNLK2, 1'b0, CODE_KEY2};
      3'd2: return '{AS_UNLK1, 1'b0, (op == OP_PROG) ? CODE_PROG :
                                     (op == OP_ID)   ? CODE_IDENT : CODE_ERASE};
      3'd3: return (op == OP_PROG) ? '{AS_CMD, 1'b1, 8'h00} : '{AS_UNLK1, 1'b0, CODE_KEY1};
      3'd4: return '{AS_UNLK2, 1'b0, CODE_KEY2};
      default: return (op == OP_SECT) ? '{AS_CMD, 1'b0, CODE_SECT} : '{AS_UNLK1, 1'b0, CODE_CHIP};
    endcase
  endfunction

  assign opIn    = (cmdOp > 3'd5) ? OP_RST : opKind_e'(cmdOp);
  assign polling = (opQ == OP_PROG) || (opQ == OP_SECT) || (opQ == OP_CHIP);
  assign lastWr  = (wrIdx == lastIdx(opQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opQ      <= OP_READ;
      wrIdx    <= '0;
      cnt      <= '0;
      exitWr   <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmdValid) begin
          opQ      <= opIn;
          wrIdx    <= '0;
          cnt      <= '0;
          timedOut <= 1'b0;
          exitWr   <= (opIn == OP_RST);
          state    <= (opIn == OP_READ) ? ST_RACC : ST_WSET;
        end
        ST_WSET: state <= ST_WLOW;
        ST_WLOW: begin
          if (cnt == CNT_W'(WP_CYC - 1)) begin cnt <= '0; state <= ST_WHIGH; end
          else cnt <= cnt + 1'b1;
        end
        ST_WHIGH: begin
          if (cnt == CNT_W'(WPH_CYC - 1)) begin
            cnt <= '0;
            if (exitWr)      state <= ST_DONE;
            else if (lastWr) state <= ST_RACC;
            else begin wrIdx <= wrIdx + 1'b1; state <= ST_WSET; end
          end else cnt <= cnt + 1'b1;
        end
        ST_RACC: begin
          if (cnt == CNT_W'(ACC_CYC - 1)) begin cnt <= '0; state <= ST_RGAP; end
          else cnt <= cnt + 1'b1;
        end
        ST_RGAP: state <= ST_REVAL;
        ST_REVAL: begin
          if (opQ == OP_READ) state <= ST_DONE;
          else if (opQ == OP_ID) begin exitWr <= 1'b1; state <= ST_WSET; end
          else if (pollOk) state <= ST_DONE;
          else if (timer >= TMR_W'(TIMEOUT_CYC)) begin
            timedOut <= 1'b1;
            exitWr   <= 1'b1;
            state    <= ST_WSET;
          end else state <= ST_RACC;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || state == ST_IDLE) timer <= '0;
    else if (polling && (state == ST_RACC || state == ST_RGAP || state == ST_REVAL)
             && timer != '1)
      timer <= timer + 1'b1;
  end

  always_comb begin
    stb          = '0;
    stb.ceN      = 1'b1;
    stb.oeN      = 1'b1;
    stb.weN      = 1'b1;
    stb.step     = '{AS_CMD, 1'b0, 8'h00};
    stb.expOne   = (opQ == OP_SECT) || (opQ == OP_CHIP);
    stb.latchCmd = (state == ST_IDLE) && cmdValid;
    case (state)
      ST_WSET, ST_WLOW, ST_WHIGH: begin
        stb.drive   = 1'b1;
        stb.ceN     = (state == ST_WHIGH);
        stb.weN     = (state != ST_WLOW);
        stb.step    = exitWr ? '{AS_ZERO, 1'b0, CODE_EXIT} : stepOf(opQ, wrIdx);
        stb.pollClr = (state == ST_WHIGH) && !exitWr && lastWr;
      end
      ST_RACC: begin
        stb.ceN     = 1'b0;
        stb.oeN     = 1'b0;
        stb.step    = '{(opQ == OP_ID) ? AS_IDOFS : AS_CMD, 1'b0, 8'h00};
        stb.capture = (cnt == CNT_W'(ACC_CYC - 1));
      end
      ST_REVAL: stb.pollStep = polling;
      default: ;
    endcase
  end

  assign cmdReady   = (state == ST_IDLE);
  assign rspDone    = (state == ST_DONE);
  assign rspTimeout = (state == ST_DONE) && timedOut;

  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R7
  poll_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REVAL && polling && pollOk) |=> (rspDone && !rspTimeout));

  // R9
  abort_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspTimeout |-> ($past(state == ST_WHIGH) && $past(exitWr)));

endmodule

// File: rtl/flashctl_top.sv
`timescale 1ns/1ps
module flashctl_top
  import flashctl_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int WP_CYC      = 3,
  parameter int WPH_CYC     = 2,
  parameter int ACC_CYC     = 5,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              pollToggle,
  output logic              rspDone,
  output logic [7:0]        rspData,
  output logic              rspTimeout,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDqOut,
  output logic              flDqOe,
  input  logic [7:0]        flDqIn,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  strobe_t stb;
  logic    pollOk;

  flashctl_ctrl #(
    .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC), .ACC_CYC(ACC_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .pollOk(pollOk),
    .cmdReady(cmdReady), .stb(stb), .rspDone(rspDone), .rspTimeout(rspTimeout)
  );

  flashctl_dp #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .pollToggle(pollToggle), .flDqIn(flDqIn), .flAddr(flAddr), .flDqOut(flDqOut),
    .flDqOe(flDqOe), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN),
    .rdData(rspData), .pollOk(pollOk)
  );

endmodule

// File: tb/flashctl_top_tb_top.sv
`timescale 1ns/1ps
module flashctl_top_tb_top;

  localparam int AW   = 19;
  localparam int WP   = 3;
  localparam int WPH  = 2;
  localparam int ACC  = 5;
  localparam int TMO  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdOp = 3'd0;
  logic [AW-1:0] cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic pollToggle = 1'b0;
  logic rspDone, rspTimeout;
  logic [7:0] rspData;
  logic [AW-1:0] flAddr;
  logic [7:0] flDqOut, flDqIn;
  logic flDqOe, flCeN, flOeN, flWeN;

  always #2.5 clk = ~clk;

  flashctl_top #(.ADDR_W(AW), .WP_CYC(WP), .WPH_CYC(WPH), .ACC_CYC(ACC), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .pollToggle(pollToggle), .rspDone(rspDone),
    .rspData(rspData), .rspTimeout(rspTimeout), .flAddr(flAddr), .flDqOut(flDqOut),
    .flDqOe(flDqOe), .flDqIn(flDqIn), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // flash model state
  logic [AW-1:0] wrA [0:15];
  logic [7:0]    wrD [0:15];
  int nWr = 0, nRd = 0, tmErr = 0;
  int busyCfg = 0, busyLeft = 0;
  bit holdFinal = 0, idMode = 0, haveWr = 0;
  logic [7:0] finalD = 8'h00, prevD = 8'h00;
  logic togBit = 1'b0;
  int weLow = 0, weHigh = 0, oeLow = 0;
  logic weQ = 1'b1, oeQ = 1'b1, dqOeQ = 1'b0, ceQ = 1'b1;
  logic [AW-1:0] aQ = '0;
  logic [7:0] dQ = '0;
  logic [7:0] modelOut;

  function automatic logic [7:0] pat(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb begin
    if (busyLeft > 0)   modelOut = {~finalD[7], togBit, 6'b0};
    else if (holdFinal) modelOut = finalD;
    else if (idMode)    modelOut = (flAddr == 0) ? 8'h3C : (flAddr == 1) ? 8'h81 : 8'h00;
    else                modelOut = pat(flAddr);
  end
  assign flDqIn = (!flCeN && !flOeN) ? modelOut : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      if (!flWeN && !flOeN) tmErr++;
      if (!flWeN) begin
        if (weQ) begin
          if (!(flAddr == aQ && flDqOut == dQ && dqOeQ && !ceQ)) tmErr++;
          if (haveWr && weHigh < WPH) tmErr++;
        end
        weLow++;
      end else begin
        if (!weQ) begin
          if (weLow != WP || !flDqOe || flDqOut != dQ) tmErr++;
          if (nWr < 16) begin wrA[nWr] = flAddr; wrD[nWr] = flDqOut; end
          nWr++;
          haveWr = 1;
          weHigh = 0;
          if (flDqOut == 8'hF0) begin busyLeft = 0; holdFinal = 0; idMode = 0; end
          else if (prevD == 8'hA0) begin
            finalD = flDqOut; busyLeft = busyCfg; holdFinal = 1; togBit = flDqOut[6] ^ busyCfg[0];
          end else if ((flDqOut == 8'h30 || flDqOut == 8'h10) && prevD == 8'h55) begin
            finalD = 8'hFF; busyLeft = busyCfg; holdFinal = 1; togBit = 1'b1 ^ busyCfg[0];
          end else if (flDqOut == 8'h90) idMode = 1;
          prevD = flDqOut;
        end
        weHigh++;
        weLow = 0;
      end
      if (!flOeN) begin
        if (flDqOe) tmErr++;
        oeLow++;
      end else begin
        if (!oeQ) begin
          if (oeLow != ACC) tmErr++;
          nRd++;
          if (busyLeft > 0) begin busyLeft--; togBit = ~togBit; end
        end
        oeLow = 0;
      end
      weQ = flWeN; oeQ = flOeN; aQ = flAddr; dQ = flDqOut; dqOeQ = flDqOe; ceQ = flCeN;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int lat;
  logic [7:0] gotData;
  logic gotTmo;

  task automatic runCmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic tog, input bit holdBusy, output int busyErr);
    busyErr = 0;
    nWr = 0; nRd = 0; holdFinal = 0; busyLeft = 0; prevD = 8'h00;
    @(negedge clk);
    cmdOp = op; cmdAddr = a; cmdData = d; pollToggle = tog; cmdValid = 1'b1;
    @(negedge clk);
    if (holdBusy) cmdOp = 3'd0; else cmdValid = 1'b0;
    lat = 0;
    while (!rspDone && lat < 3000) begin
      if (cmdReady) busyErr++;
      @(negedge clk);
      lat++;
    end
    cmdValid = 1'b0;
    gotData = rspData;
    gotTmo = rspTimeout;
    if (lat >= 3000) chk(0, "watchdog-cmd", lat, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expWrite(input logic [2:0] op, input int idx, input logic [AW-1:0] a,
                          input logic [7:0] d, output logic [AW-1:0] ea, output logic [7:0] ed);
    case (idx)
      0: begin ea = 19'h05555; ed = 8'hAA; end
      1: begin ea = 19'h02AAA; ed = 8'h55; end
      2: begin ea = 19'h05555; ed = (op == 3'd1) ? 8'hA0 : (op == 3'd4) ? 8'h90 : 8'h80; end
      3: if (op == 3'd1) begin ea = a; ed = d; end
         else if (op == 3'd4) begin ea = '0; ed = 8'hF0; end
         else begin ea = 19'h05555; ed = 8'hAA; end
      4: begin ea = 19'h02AAA; ed = 8'h55; end
      default: if (op == 3'd2) begin ea = a; ed = 8'h30; end
               else begin ea = 19'h05555; ed = 8'h10; end
    endcase
  endtask

  task automatic chkWrites(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                           input int n, input string req);
    bit ok;
    int bad;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    ok = (nWr == n);
    bad = -1;
    for (int i = 0; i < n && i < 16; i++) begin
      expWrite(op, i, a, d, ea, ed);
      if (ok && (wrA[i] != ea || wrD[i] != ed)) begin ok = 0; bad = i; end
    end
    if (!ok && bad >= 0) begin
      expWrite(op, bad, a, d, ea, ed);
      chk(0, req, {wrA[bad], wrD[bad]}, {ea, ed});
    end else chk(ok, req, nWr, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int be;
    logic [AW-1:0] a;
    logic [7:0] d, expD;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(flCeN && flOeN && flWeN && !flDqOe, "R1 strobes idle", {flCeN, flOeN, flWeN, flDqOe}, 4'b1110);
    chk(cmdReady && !rspDone, "R1 ready/done", {cmdReady, rspDone}, 2'b10);

    // R6 plain reads
    for (int k = 0; k < 4; k++) begin
      a = 19'h12345 + 19'(k * 24593);
      runCmd(3'd0, a, 8'h00, 1'b0, 0, be);
      chk(gotData == pat(a), "R6 read data", gotData, pat(a));
      chk(lat == ACC + 2, "R6 read latency", lat, ACC + 2);
      chk(nWr == 0 && nRd == 1, "R6 single read no write", nWr * 16 + nRd, 1);
    end

    // R11 return-to-read, including unused codes
    for (int op = 5; op < 8; op++) begin
      runCmd(3'(op), 19'h7ABCD, 8'h00, 1'b0, 0, be);
      chk(nWr == 1 && wrA[0] == 0 && wrD[0] == 8'hF0, "R11 single F0 write", {nWr[3:0], wrD[0]}, 12'h1F0);
      chk(lat == 1 + WP + WPH, "R11 latency", lat, 1 + WP + WPH);
    end

    // R10 identifier reads
    for (int k = 0; k < 2; k++) begin
      a = 19'h3FFF0 | 19'(k);
      runCmd(3'd4, a, 8'h00, 1'b0, 0, be);
      expD = (k == 0) ? 8'h3C : 8'h81;
      chk(gotData == expD, "R10 id data", gotData, expD);
      chkWrites(3'd4, a, 8'h00, 4, "R10 id writes");
    end

    // R2 R3 R4 R7 R8 sweep over kind, method and busy length
    for (int op = 1; op < 4; op++) begin
      for (int tog = 0; tog < 2; tog++) begin
        for (int n = 0; n < 5; n++) begin
          busyCfg = n;
          a = 19'h40000 + 19'(n * 1031 + tog * 77 + op * 5);
          d = 8'h13 + 8'(n * 53) + 8'(tog * 128);
          runCmd(3'(op), a, d, 1'(tog), 0, be);
          chkWrites(3'(op), a, d, (op == 1) ? 4 : 6,
                    (op == 1) ? "R2 program writes" : (op == 2) ? "R3 sector writes" : "R4 chip writes");
          if (tog == 0) chk(nRd == n + 1, "R7 bit7 poll read count", nRd, n + 1);
          else          chk(nRd == n + 2, "R8 bit6 poll read count", nRd, n + 2);
          expD = (op == 1) ? d : 8'hFF;
          chk(gotData == expD && !gotTmo, "R7 final data no timeout", {gotTmo, gotData}, {1'b0, expD});
        end
      end
    end

    // R9 timeout, both methods
    for (int tog = 0; tog < 2; tog++) begin
      busyCfg = 1000;
      runCmd(3'd1, 19'h01234, 8'h5E, 1'(tog), 0, be);
      chk(gotTmo == 1'b1, "R9 timeout flag", gotTmo, 1);
      chk(nWr == 5 && wrA[4] == 0 && wrD[4] == 8'hF0, "R9 exit write", {nWr[3:0], wrD[4]}, 12'h5F0);
    end

    // R12 request held during busy is ignored
    busyCfg = 3;
    runCmd(3'd1, 19'h00777, 8'h2C, 1'b0, 1, be);
    chk(be == 0, "R12 ready low while busy", be, 0);
    chk(nWr == 4 && nRd == 4, "R12 no extra bus activity", nWr * 16 + nRd, 4 * 16 + 4);

    // R5 R6 pulse timing over the whole run
    chk(tmErr == 0, "R5 write phase timing", tmErr, 0);
    chk(tmErr == 0, "R6 read access timing", tmErr, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule